// File: doc/BRIEF.md
# Dual Pulse-Width Modulator with Shared Modulo-255 Time Base

This block drives two pulse-width-modulated outputs from a single time base. The system clock is halved and then divided by a programmable factor (reload value plus one), and every resulting tick advances one 8-bit count. The count runs from 0 up to 254 and then wraps back to 0, so a full period is 255 counter steps.

Each channel compares the shared count against its own 8-bit duty value. The output is driven low while the duty value is larger than the count, and high otherwise. A duty of 00h therefore holds the output high, and FFh holds it low, because the count never reaches 255. A new duty value reaches the output pin at once, not at the end of the period.

A simple register port carries the divider reload value and the two duty values. Registers are written in one clock and read back combinationally. A change to the reload value is picked up at the divider's next reload, and the count is not restarted.

Top module: `dual_pwm`

## Requirements
- R1: While reset is asserted and after it is released, all three registers read 00h and both outputs are high.
- R2: Address 0 holds the divider reload value, address 1 holds the channel 0 duty, and address 2 holds the channel 1 duty. A write stores `wr_data` and reads back unchanged. Address 3 reads 00h, and a write to it changes no register.
- R3: With reload value P, the count advances once every 2×(P+1) clocks and wraps after 254, so the output period is 510×(P+1) clocks.
- R4: For a duty D in 1..254, each period the output is low for 2×(P+1)×D clocks, starting from the wrap of the count to 0.
- R5: A duty of 00h holds the output high continuously.
- R6: A duty of FFh holds the output low continuously.
- R7: A duty write is captured at the clock edge where `wr_en` is high. The output reflects the new value from the next clock edge on, without waiting for the period boundary.
- R8: A new reload value applies from the divider's next reload. From then on, the period matches the new value.
- R9: The two channels follow their own duty values independently against the same count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pwm_o | output | 2 | Channel outputs, bit i for channel i, low while duty exceeds count |

## Verification
The behaviour hardest to bring about from the ports is a change of divider value in the middle of a period. Its effect only shows up as a different spacing of output edges, one reload later. The stimulus writes random reload values while the outputs are running, skips one full period, and then times the interval between falling edges and the low time on both channels. Directed writes of 00h and FFh, and a duty change aimed at a precisely counted clock edge, cover the constant levels and the immediate-update rule.

// File: rtl/dpwm_pkg.sv
// Package: shared address map and helpers for the dual PWM block.
// Assumes a register index space where index 0 is the divider reload
// and indices 1..N are the channel duty values.
package dpwm_pkg;
    localparam int unsigned RELOAD_IDX = 0;

    // Register index of the duty value for a given channel.
    function automatic int unsigned duty_idx(input int unsigned ch);
        return ch + 1;
    endfunction
endpackage

// File: rtl/dpwm_regs.sv
// Module: register file holding the divider reload value and one duty
// value per channel. Writes are synchronous; reads are combinational.
// Assumes NUM_CH + 1 <= 2**ADDR_W. Unmapped addresses read zero and
// ignore writes.
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [DATA_W-1:0]              reload_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  duty_o
);
    localparam int NUM_REGS = NUM_CH + 1;

    logic [DATA_W-1:0]             reload_q;
    logic [NUM_CH-1:0][DATA_W-1:0] duty_q;
    logic                          mapped_wr;

    // Store the divider reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(RELOAD_IDX))
            reload_q <= wr_data;
    end

    // One duty register per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_duty
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(duty_idx(i)))
                duty_q[i] <= wr_data;
        end
    end

    // Readback multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(RELOAD_IDX))
            rd_data = reload_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(duty_idx(i)))
                rd_data = duty_q[i];
        end
    end

    // Flags a write that targets a mapped register.
    always_comb mapped_wr = wr_en && (int'(wr_addr) < NUM_REGS);

    assign reload_o = reload_q;
    assign duty_o   = duty_q;

    // R2
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mapped_wr) |=> ($stable(reload_q) && $stable(duty_q)));
endmodule

// File: rtl/dpwm_timebase.sv
// Module: shared time base. It halves the clock, divides by
// (reload + 1), and steps a counter from 0 to 2**DATA_W - 2 before
// wrapping. A new reload value is taken only when the divider reloads,
// so the counter is never restarted by a write.
module dpwm_timebase #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] cnt_o
);
    localparam logic [DATA_W-1:0] CNT_TOP = DATA_W'((2 ** DATA_W) - 2);

    logic              half_q;
    logic [DATA_W-1:0] pre_q;
    logic [DATA_W-1:0] active_q;
    logic [DATA_W-1:0] cnt_q;
    logic              pre_wrap;

    // Divide the system clock by two.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    always_comb pre_wrap = half_q && (pre_q == active_q);

    // Divider count; latches the new reload value when it wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            active_q <= '0;
        end else if (pre_wrap) begin
            pre_q    <= '0;
            active_q <= reload_i;
        end else if (half_q) begin
            pre_q    <= pre_q + 1'b1;
        end
    end

    // Shared period counter, modulo (2**DATA_W - 1).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pre_wrap)
            cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |->
            ((cnt_q == $past(cnt_q) + 1'b1) ||
             ($past(cnt_q) == CNT_TOP && cnt_q == '0)));
    // R8
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= active_q);
endmodule

// File: rtl/dpwm_channel.sv
// Module: one PWM channel. It drives its output low while the duty
// value is larger than the shared count. The output is registered, so
// a duty change shows up one clock after it is stored, and the output
// is high during reset.
module dpwm_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] duty_i,
    output logic              pwm_o
);
    localparam logic [DATA_W-1:0] DUTY_MAX = '1;

    logic pwm_q;

    // Glitch-free output register for the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b1;
        else        pwm_q <= !(duty_i > cnt_i);
    end

    assign pwm_o = pwm_q;

    // R5
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |=> pwm_q);
    // R6
    duty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == DUTY_MAX) |=> !pwm_q);
endmodule

// File: rtl/dual_pwm.sv
// Module: top level of the dual PWM. It holds the register file and the
// shared time base, and instantiates one comparator channel per output.
// Assumes a single clock domain and a synchronous active-low reset.
module dual_pwm #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [DATA_W-1:0]             reload;
    logic [NUM_CH-1:0][DATA_W-1:0] duty;
    logic [DATA_W-1:0]             cnt;

    dpwm_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .reload_o(reload), .duty_o(duty)
    );

    dpwm_timebase #(.DATA_W(DATA_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .reload_i(reload), .cnt_o(cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dpwm_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .duty_i(duty[i]),
            .pwm_o(pwm_o[i])
        );
    end

    // R1
    reset_high_chk: assert property (@(posedge clk)
        (!rst_n) |=> (pwm_o == '1));
endmodule

// File: tb/sim_dual_pwm.sv
// Bench: directed corner cases plus seeded random reload and duty values,
// checked against timings computed from the requirements.
module sim_dual_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] pwm_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_pwm u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
                 .pwm_o(pwm_o));

    function automatic int exp_period(input int p);
        return 510 * (p + 1);
    endfunction
    function automatic int exp_low(input int p, input int d);
        return 2 * (p + 1) * d;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [1:0] a,
                              input logic [7:0] expv);
        rd_addr = a;
        #1;
        check(req, rd_data, expv);
    endtask

    task automatic wait_level(input int ch, input logic v);
        int guard = 0;
        while (pwm_o[ch] !== v && !timed_out) begin
            @(negedge clk);
            guard++;
            if (guard > 9000) timed_out = 1'b1;
        end
    endtask

    // Times one period and the low interval of a channel.
    task automatic measure(input int ch, output int period, output int low);
        int t0, t1;
        wait_level(ch, 1'b1);
        wait_level(ch, 1'b0);
        t0 = cyc;
        wait_level(ch, 1'b1);
        t1 = cyc;
        wait_level(ch, 1'b0);
        low = t1 - t0;
        period = cyc - t0;
    endtask

    task automatic hold_check(input string req, input int ch, input logic v,
                              input int n);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_o[ch] !== v) bad++;
        end
        check(req, bad, 0);
    endtask

    initial begin
        int per, low, p, d0, d1;
        void'($urandom(32'd20250));
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        check("R1 out in reset", pwm_o, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1 reload", 2'd0, 8'h00);
        read_check("R1 duty0", 2'd1, 8'h00);
        read_check("R1 duty1", 2'd2, 8'h00);
        hold_check("R1 R5 high after reset", 0, 1'b1, 600);
        check("R1 out1 high", pwm_o[1], 1'b1);

        // R2: readback and unmapped address
        write_reg(2'd0, 8'h02);
        write_reg(2'd1, 8'h5A);
        write_reg(2'd2, 8'hC3);
        write_reg(2'd3, 8'hFF);
        read_check("R2 reload", 2'd0, 8'h02);
        read_check("R2 duty0", 2'd1, 8'h5A);
        read_check("R2 duty1", 2'd2, 8'hC3);
        read_check("R2 addr3", 2'd3, 8'h00);

        // R7: immediate duty update
        write_reg(2'd0, 8'h00);
        write_reg(2'd1, 8'h00);
        repeat (4) @(negedge clk);
        write_reg(2'd1, 8'hFF);
        check("R7 old value at capture edge", pwm_o[0], 1'b1);
        @(negedge clk);
        check("R7 new value next edge", pwm_o[0], 1'b0);
        // R6: constant low
        hold_check("R6 FFh low", 0, 1'b0, 1100);
        // R5: back to constant high
        write_reg(2'd1, 8'h00);
        hold_check("R5 00h high", 0, 1'b1, 1100);

        // R3 R4 R8 R9: random reload and duty values during operation
        for (int t = 0; t < 5; t++) begin
            p  = int'($urandom_range(0, 3));
            d0 = int'($urandom_range(1, 254));
            d1 = int'($urandom_range(1, 254));
            if (t == 0) begin d0 = 1; d1 = 254; end
            write_reg(2'd0, 8'(p));
            write_reg(2'd1, 8'(d0));
            write_reg(2'd2, 8'(d1));
            measure(0, per, low); // settle past the next reload
            measure(0, per, low);
            check("R3 R8 period", per, exp_period(p));
            check("R4 low ch0", low, exp_low(p, d0));
            measure(1, per, low);
            check("R9 R4 low ch1", low, exp_low(p, d1));
            check("R9 period ch1", per, exp_period(p));
        end
        if (timed_out) check("watchdog edge wait", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule